// File: doc/BRIEF.md
# System Register Push-Store Executor

This block executes the family of 16-bit opcodes that copy a control or system register somewhere else in a 32-bit RISC core. There are three forms. The first pushes a control register or one of eight banked general registers onto a stack addressed by a general register. The second moves a multiply-accumulate half or the procedure-return register into a general register. The third pushes one of those system registers onto a stack. A push first lowers the pointer register by four and then writes the 32-bit source value to the new address through a plain data write port.

The core presents an opcode with a valid strobe while the block is idle, along with the current privilege level and the live register values. The block captures the source value and the destination index at that issue edge. It then runs the instruction for its fixed cycle count. During that time it reads the pointer register, writes the general register file and drives the memory write. Most control-register pushes may only run in privileged mode. If one is issued in user mode, the block raises a fault pulse and changes nothing. An unassigned source selector inside one of the three groups raises an illegal-instruction pulse, also with no side effect. The block has no condition-flag output, so none of these forms can alter the core's T bit.

Top module: `sysreg_store_exec`

## Requirements
- R1: An opcode matching 0100nnnn_ssss0011, issued in privileged mode, pushes the selected source onto the stack addressed by general register n. Selector ssss maps as follows: 0000 status, 0001 global base, 0010 vector base, 0011 saved status, 0100 saved PC, and 1bbb banked register b. Register n becomes its old value minus 4, and the source word is stored at that new address.
- R2: The global-base push (ssss = 0001) runs in user mode exactly as it does in privileged mode.
- R3: Any other valid control-register push issued in user mode leaves register n and memory untouched and does not set busy. Instead, priv_fault is high for exactly the one cycle after the issue edge.
- R4: A control-register push keeps busy high for 2 cycles after the issue edge. In the first cycle it writes n with the decremented value. In the second cycle it writes memory and raises done.
- R5: An opcode matching 0000nnnn_00xx1010 copies a system register into register n, with xx = 00 MAC high, 01 MAC low, 10 return register. It is busy for 1 cycle, raises done in that cycle, and makes no memory write.
- R6: An opcode matching 0100nnnn_00xx0010, using the same xx map, pushes that system register. It is busy for 1 cycle, and the register write, memory write and done all happen in that single cycle. No privilege is needed.
- R7: A selector of 0101, 0110 or 0111 in the control-push group, or xx = 11 in either system group, raises illegal for exactly the one cycle after issue, with no register write, memory write or busy.
- R8: An issue strobe seen while busy is ignored. An opcode outside the three groups produces no busy, write or flag.
- R9: The stored or moved value is the one the source had at the issue edge, even if the source changes later.
- R10: After reset, busy, done, wr_en, mem_we, priv_fault and illegal are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | Opcode is valid; accepted when not busy |
| opcode | input | 16 | Instruction word |
| priv_mode | input | 1 | 1 = privileged, 0 = user |
| sr_in | input | 32 | Status register value |
| gbr_in | input | 32 | Global base register value |
| vbr_in | input | 32 | Vector base register value |
| ssr_in | input | 32 | Saved status register value |
| spc_in | input | 32 | Saved PC value |
| bank_flat | input | 256 | Banked registers 0..7, register b at bits [32b+31:32b] |
| mach_in | input | 32 | MAC high half |
| macl_in | input | 32 | MAC low half |
| pr_in | input | 32 | Procedure return register |
| rd_idx | output | 4 | Register file read index (pointer register) |
| rd_data | input | 32 | Register file read data, combinational |
| wr_en | output | 1 | Register file write enable |
| wr_idx | output | 4 | Register file write index |
| wr_data | output | 32 | Register file write data |
| mem_we | output | 1 | Memory word write strobe |
| mem_addr | output | 32 | Memory write address |
| mem_wdata | output | 32 | Memory write data |
| busy | output | 1 | Instruction in execution |
| done | output | 1 | Final execution cycle |
| priv_fault | output | 1 | Privilege-violation pulse |
| illegal | output | 1 | Illegal-selector pulse |

## Verification
Every result is due at a fixed cycle counted from the accepting edge. Fault and illegal pulses, and the register write of every form, appear in the first cycle after that edge. A system-register push also writes memory and raises done in that first cycle. A control-register push writes memory and raises done in the second cycle, and busy falls in the third. The bench drives the issue at a falling edge, then steps one falling edge at a time. At each one it compares every output against values derived from the opcode and its own register-file model, so a result one cycle early or late is reported.

// File: rtl/sse_pkg.sv
`timescale 1ns/1ps
package sse_pkg;
  localparam int BANK_COUNT = 8;
  localparam int BANK_IDX_W = 3;

  typedef enum logic [1:0] {
    OPK_NONE,
    OPK_CTL_PUSH,
    OPK_SYS_MOVE,
    OPK_SYS_PUSH
  } opk_e;

  typedef enum logic [3:0] {
    SRC_STATUS,
    SRC_GLOBAL,
    SRC_VECTOR,
    SRC_SAVED_ST,
    SRC_SAVED_PC,
    SRC_MAC_HI,
    SRC_MAC_LO,
    SRC_RET,
    SRC_BANK
  } src_e;

  typedef struct packed {
    opk_e                  kind;
    src_e                  src;
    logic [BANK_IDX_W-1:0] bank;
    logic [3:0]            rn;
    logic                  bad_sel;
    logic                  priv_only;
  } dec_t;
endpackage

// File: rtl/sse_decode.sv
`timescale 1ns/1ps
module sse_decode
  import sse_pkg::*;
(
  input  logic [15:0] opcode,
  output dec_t        dec
);
  logic is_ctl;
  logic is_sys;

  always_comb begin
    is_ctl = (opcode[15:12] == 4'h4) && (opcode[3:0] == 4'h3);
    is_sys = (opcode[7:6] == 2'b00) &&
             (((opcode[15:12] == 4'h4) && (opcode[3:0] == 4'h2)) ||
              ((opcode[15:12] == 4'h0) && (opcode[3:0] == 4'hA)));
  end

  always_comb begin
    dec           = '0;
    dec.kind      = OPK_NONE;
    dec.src       = SRC_STATUS;
    dec.rn        = opcode[11:8];
    dec.bank      = opcode[6:4];
    if (is_ctl) begin
      dec.kind      = OPK_CTL_PUSH;
      dec.priv_only = (opcode[7:4] != 4'h1);
      if (opcode[7]) begin
        dec.src = SRC_BANK;
      end else begin
        case (opcode[6:4])
          3'd0:    dec.src = SRC_STATUS;
          3'd1:    dec.src = SRC_GLOBAL;
          3'd2:    dec.src = SRC_VECTOR;
          3'd3:    dec.src = SRC_SAVED_ST;
          3'd4:    dec.src = SRC_SAVED_PC;
          default: begin
            dec.bad_sel   = 1'b1;
            dec.priv_only = 1'b0;
          end
        endcase
      end
    end else if (is_sys) begin
      dec.kind = opcode[14] ? OPK_SYS_PUSH : OPK_SYS_MOVE;
      case (opcode[5:4])
        2'd0:    dec.src = SRC_MAC_HI;
        2'd1:    dec.src = SRC_MAC_LO;
        2'd2:    dec.src = SRC_RET;
        default: dec.bad_sel = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/sse_src_mux.sv
`timescale 1ns/1ps
module sse_src_mux
  import sse_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  src_e                       src,
  input  logic [BANK_IDX_W-1:0]      bank,
  input  logic [XLEN-1:0]            sr_in,
  input  logic [XLEN-1:0]            gbr_in,
  input  logic [XLEN-1:0]            vbr_in,
  input  logic [XLEN-1:0]            ssr_in,
  input  logic [XLEN-1:0]            spc_in,
  input  logic [BANK_COUNT*XLEN-1:0] bank_flat,
  input  logic [XLEN-1:0]            mach_in,
  input  logic [XLEN-1:0]            macl_in,
  input  logic [XLEN-1:0]            pr_in,
  output logic [XLEN-1:0]            value
);
  logic [XLEN-1:0] bank_arr [BANK_COUNT];

  for (genvar g = 0; g < BANK_COUNT; g++) begin : g_bank
    assign bank_arr[g] = bank_flat[g*XLEN +: XLEN];
  end

  always_comb begin
    case (src)
      SRC_STATUS:   value = sr_in;
      SRC_GLOBAL:   value = gbr_in;
      SRC_VECTOR:   value = vbr_in;
      SRC_SAVED_ST: value = ssr_in;
      SRC_SAVED_PC: value = spc_in;
      SRC_MAC_HI:   value = mach_in;
      SRC_MAC_LO:   value = macl_in;
      SRC_RET:      value = pr_in;
      SRC_BANK:     value = bank_arr[bank];
      default:      value = '0;
    endcase
  end
endmodule

// File: rtl/sse_seq.sv
`timescale 1ns/1ps
module sse_seq
  import sse_pkg::*;
#(
  parameter int XLEN         = 32,
  parameter int CTL_CYC      = 2,
  parameter int SYS_MOVE_CYC = 1,
  parameter int SYS_PUSH_CYC = 1,
  parameter int STEP         = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue_valid,
  input  dec_t            dec,
  input  logic            priv_mode,
  input  logic [XLEN-1:0] src_val,
  input  logic [XLEN-1:0] rd_data,
  output logic [3:0]      rd_idx,
  output logic            wr_en,
  output logic [3:0]      wr_idx,
  output logic [XLEN-1:0] wr_data,
  output logic            mem_we,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  output logic            busy,
  output logic            done,
  output logic            priv_fault,
  output logic            illegal
);
  localparam int MAX_A   = (CTL_CYC > SYS_MOVE_CYC) ? CTL_CYC : SYS_MOVE_CYC;
  localparam int MAX_CYC = (MAX_A > SYS_PUSH_CYC) ? MAX_A : SYS_PUSH_CYC;
  localparam int CW      = $clog2(MAX_CYC + 1);

  logic [CW-1:0]   cnt_q, cnt_d;
  logic            first_q, first_d;
  logic            pf_q, pf_d;
  logic            il_q, il_d;
  opk_e            kind_q;
  logic [3:0]      rn_q;
  logic [XLEN-1:0] val_q;
  logic [XLEN-1:0] addr_q, addr_d;

  logic            accept, start, deny, known;
  logic            addr_en;
  logic [CW-1:0]   cyc_sel;
  logic [XLEN-1:0] addr_calc;
  logic            is_push;

  // next-state logic
  always_comb begin
    accept  = issue_valid && (cnt_q == '0);
    known   = (dec.kind != OPK_NONE);
    deny    = dec.priv_only && !priv_mode;
    start   = accept && known && !dec.bad_sel && !deny;
    pf_d    = accept && known && !dec.bad_sel && deny;
    il_d    = accept && known && dec.bad_sel;

    case (dec.kind)
      OPK_CTL_PUSH: cyc_sel = CW'(CTL_CYC);
      OPK_SYS_MOVE: cyc_sel = CW'(SYS_MOVE_CYC);
      OPK_SYS_PUSH: cyc_sel = CW'(SYS_PUSH_CYC);
      default:      cyc_sel = '0;
    endcase

    if (start)              cnt_d = cyc_sel;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    else                    cnt_d = cnt_q;

    if (start)              first_d = 1'b1;
    else if (cnt_q != '0)   first_d = 1'b0;
    else                    first_d = first_q;

    addr_calc = rd_data - XLEN'(STEP);
    addr_en   = (cnt_q != '0) && first_q;
    addr_d    = addr_en ? addr_calc : addr_q;
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      first_q <= 1'b0;
      pf_q    <= 1'b0;
      il_q    <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      first_q <= first_d;
      pf_q    <= pf_d;
      il_q    <= il_d;
    end
  end

  // datapath registers, clock-enabled
  always_ff @(posedge clk) begin
    if (start) begin
      kind_q <= dec.kind;
      rn_q   <= dec.rn;
      val_q  <= src_val;
    end
    if (addr_en) begin
      addr_q <= addr_d;
    end
  end

  // outputs
  always_comb begin
    busy       = (cnt_q != '0);
    done       = (cnt_q == CW'(1));
    is_push    = (kind_q != OPK_SYS_MOVE);
    rd_idx     = rn_q;
    wr_en      = busy && first_q;
    wr_idx     = rn_q;
    wr_data    = is_push ? addr_calc : val_q;
    mem_we     = done && is_push;
    mem_addr   = first_q ? addr_calc : addr_q;
    mem_wdata  = val_q;
    priv_fault = pf_q;
    illegal    = il_q;
  end
endmodule

// File: rtl/sysreg_store_exec.sv
`timescale 1ns/1ps
module sysreg_store_exec
  import sse_pkg::*;
#(
  parameter int XLEN         = 32,
  parameter int CTL_CYC      = 2,
  parameter int SYS_MOVE_CYC = 1,
  parameter int SYS_PUSH_CYC = 1,
  parameter int STEP         = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       issue_valid,
  input  logic [15:0]                opcode,
  input  logic                       priv_mode,
  input  logic [XLEN-1:0]            sr_in,
  input  logic [XLEN-1:0]            gbr_in,
  input  logic [XLEN-1:0]            vbr_in,
  input  logic [XLEN-1:0]            ssr_in,
  input  logic [XLEN-1:0]            spc_in,
  input  logic [BANK_COUNT*XLEN-1:0] bank_flat,
  input  logic [XLEN-1:0]            mach_in,
  input  logic [XLEN-1:0]            macl_in,
  input  logic [XLEN-1:0]            pr_in,
  output logic [3:0]                 rd_idx,
  input  logic [XLEN-1:0]            rd_data,
  output logic                       wr_en,
  output logic [3:0]                 wr_idx,
  output logic [XLEN-1:0]            wr_data,
  output logic                       mem_we,
  output logic [XLEN-1:0]            mem_addr,
  output logic [XLEN-1:0]            mem_wdata,
  output logic                       busy,
  output logic                       done,
  output logic                       priv_fault,
  output logic                       illegal
);
  dec_t            dec;
  logic [XLEN-1:0] src_val;

  sse_decode u_dec (
    .opcode (opcode),
    .dec    (dec)
  );

  sse_src_mux #(.XLEN(XLEN)) u_mux (
    .src       (dec.src),
    .bank      (dec.bank),
    .sr_in     (sr_in),
    .gbr_in    (gbr_in),
    .vbr_in    (vbr_in),
    .ssr_in    (ssr_in),
    .spc_in    (spc_in),
    .bank_flat (bank_flat),
    .mach_in   (mach_in),
    .macl_in   (macl_in),
    .pr_in     (pr_in),
    .value     (src_val)
  );

  sse_seq #(
    .XLEN         (XLEN),
    .CTL_CYC      (CTL_CYC),
    .SYS_MOVE_CYC (SYS_MOVE_CYC),
    .SYS_PUSH_CYC (SYS_PUSH_CYC),
    .STEP         (STEP)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_valid (issue_valid),
    .dec         (dec),
    .priv_mode   (priv_mode),
    .src_val     (src_val),
    .rd_data     (rd_data),
    .rd_idx      (rd_idx),
    .wr_en       (wr_en),
    .wr_idx      (wr_idx),
    .wr_data     (wr_data),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .busy        (busy),
    .done        (done),
    .priv_fault  (priv_fault),
    .illegal     (illegal)
  );
endmodule

// File: rtl/sse_checker.sv
`timescale 1ns/1ps
module sse_checker (
  input logic clk,
  input logic rst_n,
  input logic issue_valid,
  input logic wr_en,
  input logic mem_we,
  input logic busy,
  input logic done,
  input logic priv_fault,
  input logic illegal
);
  AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    priv_fault |-> (!wr_en && !mem_we && !busy)); // R3

  AST_STORE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy); // R4

  AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R4

  AST_WRITE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> busy); // R5

  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!wr_en && !mem_we && !busy)); // R7

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({priv_fault, illegal, done})); // R7

  AST_BUSY_NEEDS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(issue_valid)); // R8

  AST_FAULT_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    priv_fault |-> !$past(busy)); // R8
endmodule

bind sysreg_store_exec sse_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .issue_valid (issue_valid),
  .wr_en       (wr_en),
  .mem_we      (mem_we),
  .busy        (busy),
  .done        (done),
  .priv_fault  (priv_fault),
  .illegal     (illegal)
);

// File: tb/sysreg_store_exec_test.sv
`timescale 1ns/1ps
module sysreg_store_exec_test;
  logic         clk;
  logic         rst_n;
  logic         issue_valid;
  logic [15:0]  opcode;
  logic         priv_mode;
  logic [31:0]  sr_in, gbr_in, vbr_in, ssr_in, spc_in;
  logic [255:0] bank_flat;
  logic [31:0]  mach_in, macl_in, pr_in;
  logic [3:0]   rd_idx;
  logic [31:0]  rd_data;
  logic         wr_en;
  logic [3:0]   wr_idx;
  logic [31:0]  wr_data;
  logic         mem_we;
  logic [31:0]  mem_addr, mem_wdata;
  logic         busy, done, priv_fault, illegal;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  logic [31:0] gpr [16];
  logic [31:0] model [16];

  sysreg_store_exec uut (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .opcode(opcode),
    .priv_mode(priv_mode), .sr_in(sr_in), .gbr_in(gbr_in), .vbr_in(vbr_in),
    .ssr_in(ssr_in), .spc_in(spc_in), .bank_flat(bank_flat),
    .mach_in(mach_in), .macl_in(macl_in), .pr_in(pr_in),
    .rd_idx(rd_idx), .rd_data(rd_data), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .busy(busy), .done(done),
    .priv_fault(priv_fault), .illegal(illegal)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  assign rd_data = gpr[rd_idx];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) gpr[i] <= 32'h1000_0000 + 32'(i) * 32'h140;
    end else if (wr_en) begin
      gpr[wr_idx] <= wr_data;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_src(input logic [15:0] op);
    logic ctl;
    ctl = (op[3:0] == 4'h3);
    if (ctl) begin
      if (op[7]) return bank_flat[32*int'(op[6:4]) +: 32];
      case (op[6:4])
        3'd0: return sr_in;
        3'd1: return gbr_in;
        3'd2: return vbr_in;
        3'd3: return ssr_in;
        default: return spc_in;
      endcase
    end
    case (op[5:4])
      2'd0: return mach_in;
      2'd1: return macl_in;
      default: return pr_in;
    endcase
  endfunction

  // Issue one opcode and check every cycle of its execution.
  task automatic run_op(input logic [15:0] op, input bit pm);
    bit ctl, sysp, sysm, bad, deny;
    logic [3:0] n;
    logic [31:0] old, src;
    string tg;
    n    = op[11:8];
    ctl  = (op[15:12] == 4'h4) && (op[3:0] == 4'h3);
    sysp = (op[15:12] == 4'h4) && (op[7:6] == 2'b00) && (op[3:0] == 4'h2);
    sysm = (op[15:12] == 4'h0) && (op[7:6] == 2'b00) && (op[3:0] == 4'hA);
    bad  = (ctl && op[7:4] >= 4'd5 && op[7:4] <= 4'd7) || ((sysp || sysm) && op[5:4] == 2'd3);
    deny = ctl && !bad && op[7:4] != 4'd1 && !pm;
    @(negedge clk);
    issue_valid = 1'b1; opcode = op; priv_mode = pm;
    src = exp_src(op);
    old = model[n];
    @(negedge clk);
    issue_valid = 1'b0; opcode = 16'h0009;
    if (!(ctl || sysp || sysm)) begin
      chk("R8 outside busy", {31'b0, busy}, 32'd0);
      chk("R8 outside writes", {30'b0, wr_en, mem_we}, 32'd0);
      chk("R8 outside flags", {30'b0, priv_fault, illegal}, 32'd0);
    end else if (bad) begin
      chk("R7 illegal pulse", {31'b0, illegal}, 32'd1);
      chk("R7 illegal quiet", {29'b0, busy, wr_en, mem_we}, 32'd0);
      @(negedge clk);
      chk("R7 illegal one cycle", {31'b0, illegal}, 32'd0);
    end else if (deny) begin
      chk("R3 fault pulse", {31'b0, priv_fault}, 32'd1);
      chk("R3 fault quiet", {29'b0, busy, wr_en, mem_we}, 32'd0);
      @(negedge clk);
      chk("R3 fault one cycle", {31'b0, priv_fault}, 32'd0);
    end else if (ctl) begin
      tg = (op[7:4] == 4'd1) ? "R2" : "R1";
      chk("R4 cyc1 busy/done", {30'b0, busy, done}, 32'd2);
      chk("R4 cyc1 no store", {31'b0, mem_we}, 32'd0);
      chk({tg, " rn write"}, {27'b0, wr_en, wr_idx}, {27'b0, 1'b1, n});
      chk({tg, " rn value"}, wr_data, old - 32'd4);
      model[n] = old - 32'd4;
      @(negedge clk);
      chk("R4 cyc2 busy/done", {30'b0, busy, done}, 32'd3);
      chk("R4 cyc2 no rn write", {31'b0, wr_en}, 32'd0);
      chk({tg, " store strobe"}, {31'b0, mem_we}, 32'd1);
      chk({tg, " store addr"}, mem_addr, old - 32'd4);
      chk({tg, " store data"}, mem_wdata, src);
      @(negedge clk);
      chk("R4 busy released", {31'b0, busy}, 32'd0);
    end else if (sysm) begin
      chk("R5 busy/done", {30'b0, busy, done}, 32'd3);
      chk("R5 write", {27'b0, wr_en, wr_idx}, {27'b0, 1'b1, n});
      chk("R5 value", wr_data, src);
      chk("R5 no store", {31'b0, mem_we}, 32'd0);
      model[n] = src;
      @(negedge clk);
      chk("R5 busy released", {31'b0, busy}, 32'd0);
    end else begin
      chk("R6 busy/done", {30'b0, busy, done}, 32'd3);
      chk("R6 write", {27'b0, wr_en, wr_idx}, {27'b0, 1'b1, n});
      chk("R6 rn value", wr_data, old - 32'd4);
      chk("R6 store", {31'b0, mem_we}, 32'd1);
      chk("R6 store addr", mem_addr, old - 32'd4);
      chk("R6 store data", mem_wdata, src);
      model[n] = old - 32'd4;
      @(negedge clk);
      chk("R6 busy released", {31'b0, busy}, 32'd0);
    end
    chk("R3 R7 regfile state", gpr[n], model[n]);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [3:0] n;
    rst_n = 1'b0; issue_valid = 1'b0; opcode = 16'h0009; priv_mode = 1'b0;
    sr_in = 32'h5A00_00F1; gbr_in = 32'h6B11_2202; vbr_in = 32'h7C22_3303;
    ssr_in = 32'h8D33_4404; spc_in = 32'h9E44_5505;
    mach_in = 32'hA155_6606; macl_in = 32'hB266_7707; pr_in = 32'hC377_8808;
    for (int b = 0; b < 8; b++) bank_flat[32*b +: 32] = 32'hD000_0000 + 32'(b) * 32'h0101_0111;
    for (int i = 0; i < 16; i++) model[i] = 32'h1000_0000 + 32'(i) * 32'h140;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 reset outputs", {26'b0, busy, done, wr_en, mem_we, priv_fault, illegal}, 32'd0);

    // Sweep all control-push selectors in both modes (R1 R2 R3 R4 R7)
    for (int pm = 0; pm < 2; pm++)
      for (int sel = 0; sel < 16; sel++) begin
        n = 4'((sel + pm * 5) % 16);
        run_op({4'h4, n, 4'(sel), 4'h3}, pm[0]);
      end
    // System moves and pushes, all selectors, both modes (R5 R6 R7)
    for (int pm = 0; pm < 2; pm++)
      for (int xx = 0; xx < 4; xx++) begin
        n = 4'(xx * 3 + pm);
        run_op({4'h0, n, 2'b00, 2'(xx), 4'hA}, pm[0]);
        run_op({4'h4, n, 2'b00, 2'(xx), 4'h2}, pm[0]);
      end
    // Opcodes outside the groups (R8)
    run_op(16'h6003, 1'b1);
    run_op(16'h034A, 1'b1);
    run_op(16'h4272, 1'b1);
    run_op(16'h8003, 1'b0);

    // R8: issue held while busy is ignored
    @(negedge clk);
    issue_valid = 1'b1; opcode = 16'h4213; priv_mode = 1'b0;
    @(negedge clk);
    opcode = 16'h050A;
    chk("R8 first op rn write", wr_data, model[2] - 32'd4);
    model[2] = model[2] - 32'd4;
    @(negedge clk);
    chk("R8 first op store", mem_wdata, gbr_in);
    @(negedge clk);
    issue_valid = 1'b0; opcode = 16'h0009;
    chk("R8 busy-time issue ignored", {30'b0, busy, wr_en}, 32'd0);
    @(negedge clk);
    chk("R8 no second op", {30'b0, busy, wr_en}, 32'd0);
    chk("R8 r5 untouched", gpr[5], model[5]);
    chk("R8 r2 single step", gpr[2], model[2]);

    // R9: source sampled at issue (control push)
    @(negedge clk);
    issue_valid = 1'b1; opcode = 16'h4703; priv_mode = 1'b1;
    @(negedge clk);
    issue_valid = 1'b0; opcode = 16'h0009;
    sr_in = 32'hFFFF_0000;
    model[7] = model[7] - 32'd4;
    @(negedge clk);
    chk("R9 ctl push data", mem_wdata, 32'h5A00_00F1);
    chk("R9 ctl push addr", mem_addr, model[7]);
    // R9: source sampled at issue (system push)
    @(negedge clk);
    issue_valid = 1'b1; opcode = 16'h4812; priv_mode = 1'b0;
    @(negedge clk);
    issue_valid = 1'b0; opcode = 16'h0009;
    macl_in = 32'h0000_FFFF;
    chk("R9 sys push data", mem_wdata, 32'hB266_7707);
    model[8] = model[8] - 32'd4;
    @(negedge clk);
    chk("R9 regfile after push", gpr[8], model[8]);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule